// File: doc/BRIEF.md
# Byte-Wide One-Time-Programmable Memory Model

This block is a synthesizable stand-in for a byte-wide programmable read-only memory. The block is used wherever a design or a test platform needs such a part inside the chip. A host reads bytes through active-low chip-enable and output-enable controls. The same host programs bytes by pulsing an active-low program strobe while a single-bit supply qualifier stands in for the high programming voltage. Programming can only turn stored ones into zeros. A bulk-erase input puts every cell back to one, and it stands in for an ultraviolet wipe of the whole array.

A second qualifier stands for the high voltage placed on an address pin. While it is raised, a read returns one of two identifier bytes instead of the array contents, and address bit 0 picks which one. The data bus is split into an input, an output and an output-enable, which together model a three-state pin. A chip-sized build uses `ADDR_W = 14`, which gives 16384 bytes of 8 bits. The default is kept smaller so that the array stays cheap to elaborate.

Top module: `prom_byte_model`

## Requirements
- R1: The array holds 2^ADDR_W bytes of DATA_W bits. Each address is programmed and read back without disturbing any other address.
- R2: After reset, and after any clock edge at which `erase_i` is 1, every byte reads as all ones. When an erase and a program pulse meet at the same edge, the erase wins.
- R3: In program mode, a program pulse stores the old byte ANDed with `dq_i`, so a stored bit can only go from 1 to 0. The pulse is the first clock edge at which `pgm_n_i` is 0 after having been 1 at the edge before. The new value is visible on the next read. Keeping `pgm_n_i` low longer writes nothing more.
- R4: While `ce_n_i` is 1 (standby), `dq_oe_o` is 0 and `dq_o` is 0.
- R5: `dq_oe_o` is 1 only when `ce_n_i`=0, `oe_n_i`=0 and `pgm_n_i`=1. Whenever `dq_oe_o` is 0, `dq_o` is 0.
- R6: Program mode is `vpp_ok_i`=1, `oe_n_i`=1 and `ce_n_i`=0. A strobe outside program mode changes no byte.
- R7: `ce_n_i`=1 inhibits programming, even with `vpp_ok_i`=1, `oe_n_i`=1 and a strobe on `pgm_n_i`.
- R8: With `sig_hv_i`=1 and output driven, `addr_i[0]`=0 returns MFG_ID (default 8'h97) and `addr_i[0]`=1 returns DEV_ID (default 8'h83). The array contents are left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; leaves the array all ones |
| ce_n_i | input | 1 | Active-low chip enable; high means standby and program inhibit |
| oe_n_i | input | 1 | Active-low output enable |
| pgm_n_i | input | 1 | Active-low program strobe |
| vpp_ok_i | input | 1 | Programming supply qualifier |
| sig_hv_i | input | 1 | Signature qualifier (high voltage on an address pin) |
| erase_i | input | 1 | Bulk erase to all ones |
| addr_i | input | ADDR_W | Byte address |
| dq_i | input | DATA_W | Data into the part while programming |
| dq_o | output | DATA_W | Data out of the part |
| dq_oe_o | output | 1 | Drive enable of the data bus (0 models high impedance) |

## Verification
The bench builds the block with ADDR_W=10, DATA_W=8 and the default identifier bytes. This keeps the array at 1024 bytes, so the first and the last address are both reached within a short run. With 8-bit data, the 0x97/0x83 signature values can be compared literally. The same build is enough to cover every mode transition, repeated clears of the same byte, and an erase meeting a program pulse at the same edge.

// File: rtl/prom_pkg.sv
package prom_pkg;

  typedef enum logic [2:0] {
    MODE_STANDBY,
    MODE_INHIBIT,
    MODE_OUTDIS,
    MODE_READ,
    MODE_PROGRAM
  } prom_mode_e;

  // Mode from the three static controls; chip enable dominates.
  function automatic prom_mode_e decode_mode(input logic ce_n, input logic oe_n,
                                             input logic vpp_ok);
    if (ce_n)                decode_mode = vpp_ok ? MODE_INHIBIT : MODE_STANDBY;
    else if (vpp_ok && oe_n) decode_mode = MODE_PROGRAM;
    else if (!oe_n)          decode_mode = MODE_READ;
    else                     decode_mode = MODE_OUTDIS;
  endfunction

endpackage

// File: rtl/prom_mode_decode.sv
module prom_mode_decode
  import prom_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n_i,
  input  logic       oe_n_i,
  input  logic       pgm_n_i,
  input  logic       vpp_ok_i,
  output prom_mode_e mode_o,
  output logic       prog_pulse_o,
  output logic       drive_en_o
);

  logic pgm_n_q;
  logic strobe_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pgm_n_q <= 1'b1;
    else        pgm_n_q <= pgm_n_i;
  end

  assign mode_o       = decode_mode(ce_n_i, oe_n_i, vpp_ok_i);
  assign strobe_fall  = pgm_n_q && !pgm_n_i;
  assign prog_pulse_o = strobe_fall && (mode_o == MODE_PROGRAM);
  // Strobe and output drive never overlap.
  assign drive_en_o   = (mode_o == MODE_READ) && pgm_n_i;

  // R3: a pulse is a single-edge event
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    prog_pulse_o |=> !prog_pulse_o);

endmodule

// File: rtl/prom_cell_array.sv
module prom_cell_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;

  // Programming can only pull bits low.
  function automatic logic [DATA_W-1:0] clear_merge(input logic [DATA_W-1:0] old_b,
                                                    input logic [DATA_W-1:0] new_b);
    clear_merge = old_b & new_b;
  endfunction

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (erase_i) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (wr_en_i) begin
      mem[addr_i] <= clear_merge(mem[addr_i], wdata_i);
    end
  end

  assign rdata_o = mem[addr_i];

  // Checker state: remember the byte before a write and the last erase.
  logic              wr_seen_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [DATA_W-1:0] wr_old_q;
  logic              erased_q;
  logic [DATA_W-1:0] wr_new_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_seen_q <= 1'b0;
      wr_addr_q <= '0;
      wr_old_q  <= '0;
      erased_q  <= 1'b0;
    end else begin
      wr_seen_q <= wr_en_i && !erase_i;
      wr_addr_q <= addr_i;
      wr_old_q  <= mem[addr_i];
      erased_q  <= erase_i;
    end
  end

  assign wr_new_now = mem[wr_addr_q];

  // R3: no bit of a written byte rises
  p_clear_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_seen_q |-> ((wr_new_now & ~wr_old_q) == '0));

  // R2: the edge after an erase, any address reads all ones
  p_erase_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
    erased_q |-> (rdata_o == '1));

endmodule

// File: rtl/prom_out_stage.sv
module prom_out_stage #(
  parameter int          DATA_W = 8,
  parameter logic [DATA_W-1:0] MFG_ID = 8'h97,
  parameter logic [DATA_W-1:0] DEV_ID = 8'h83
) (
  input  logic              drive_en_i,
  input  logic              sig_i,
  input  logic              sel_i,
  input  logic [DATA_W-1:0] array_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);

  function automatic logic [DATA_W-1:0] id_byte(input logic sel);
    id_byte = sel ? DEV_ID : MFG_ID;
  endfunction

  logic [DATA_W-1:0] src;

  assign src     = sig_i ? id_byte(sel_i) : array_i;
  assign dq_oe_o = drive_en_i;
  assign dq_o    = drive_en_i ? src : '0;

endmodule

// File: rtl/prom_byte_model.sv
module prom_byte_model
  import prom_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] MFG_ID = 8'h97,
  parameter logic [DATA_W-1:0] DEV_ID = 8'h83
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  input  logic              pgm_n_i,
  input  logic              vpp_ok_i,
  input  logic              sig_hv_i,
  input  logic              erase_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);

  prom_mode_e        mode;
  logic              prog_pulse;
  logic              drive_en;
  logic [DATA_W-1:0] array_byte;

  prom_mode_decode u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce_n_i      (ce_n_i),
    .oe_n_i      (oe_n_i),
    .pgm_n_i     (pgm_n_i),
    .vpp_ok_i    (vpp_ok_i),
    .mode_o      (mode),
    .prog_pulse_o(prog_pulse),
    .drive_en_o  (drive_en)
  );

  prom_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk    (clk),
    .rst_n  (rst_n),
    .erase_i(erase_i),
    .wr_en_i(prog_pulse),
    .addr_i (addr_i),
    .wdata_i(dq_i),
    .rdata_o(array_byte)
  );

  prom_out_stage #(.DATA_W(DATA_W), .MFG_ID(MFG_ID), .DEV_ID(DEV_ID)) u_out (
    .drive_en_i(drive_en),
    .sig_i     (sig_hv_i),
    .sel_i     (addr_i[0]),
    .array_i   (array_byte),
    .dq_o      (dq_o),
    .dq_oe_o   (dq_oe_o)
  );

  // R4: standby floats the bus
  p_standby_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n_i |-> (!dq_oe_o && dq_o == '0));

  // R5: strobe and drive exclusive
  p_strobe_no_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !pgm_n_i |-> !dq_oe_o);

  // R7: chip enable high blocks any write
  p_inhibit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n_i |-> !prog_pulse);

  // R6: writes only with the supply qualifier and output disabled
  p_prog_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    prog_pulse |-> (vpp_ok_i && oe_n_i));

  // R8: signature replaces array data
  p_sig_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe_o && sig_hv_i) |-> (dq_o == (addr_i[0] ? DEV_ID : MFG_ID)));

endmodule

// File: tb/prom_byte_model_tb.sv
module prom_byte_model_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1, vpp = 1'b0, sig = 1'b0, er = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dq_o;
  logic          dq_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference: associative array, missing key means erased (all ones).
  logic [DW-1:0] ref_mem [int];
  logic          prev_pgm = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  prom_byte_model #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n), .oe_n_i(oe_n), .pgm_n_i(pgm_n),
    .vpp_ok_i(vpp), .sig_hv_i(sig), .erase_i(er), .addr_i(addr), .dq_i(din),
    .dq_o(dq_o), .dq_oe_o(dq_oe)
  );

  function automatic logic [DW-1:0] ref_read(input int a);
    return ref_mem.exists(a) ? ref_mem[a] : 8'hFF;
  endfunction

  task automatic check(input string req, input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One clock: apply inputs, compare outputs mid-cycle, then advance the model.
  task automatic step(input string req, input logic c, input logic o, input logic p,
                      input logic v, input logic s, input logic e,
                      input int a, input logic [DW-1:0] d);
    logic          exp_oe;
    logic [DW-1:0] exp_dq;
    ce_n = c; oe_n = o; pgm_n = p; vpp = v; sig = s; er = e;
    addr = AW'(a); din = d;
    #1;
    exp_oe = !c && !o && p;
    if (!exp_oe)   exp_dq = '0;
    else if (s)    exp_dq = a[0] ? 8'h83 : 8'h97;
    else           exp_dq = ref_read(a);
    check(req, "dq_oe", {7'd0, dq_oe}, {7'd0, exp_oe});
    check(req, "dq", dq_o, exp_dq);
    @(posedge clk);
    if (e) ref_mem.delete();
    else if (!c && o && v && !p && prev_pgm) ref_mem[a] = ref_read(a) & d;
    prev_pgm = p;
    @(negedge clk);
  endtask

  task automatic rd(input string req, input int a);
    step(req, 0, 0, 1, 0, 0, 0, a, 8'h00);
  endtask

  task automatic prog(input string req, input int a, input logic [DW-1:0] d);
    step(req, 0, 1, 1, 1, 0, 0, a, d);
    step(req, 0, 1, 0, 1, 0, 0, a, d);
    step(req, 0, 1, 1, 1, 0, 0, a, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: as-delivered all ones; R4: standby floats the bus
    rd("R2", 0); rd("R2", 5);
    step("R4", 1, 0, 1, 0, 0, 0, 5, 8'h00);
    // R3 / R1: program, then clear more bits of the same byte
    prog("R3", 5, 8'h3C); rd("R3", 5);
    prog("R3", 5, 8'hF0); rd("R3", 5); rd("R1", 4); rd("R1", 6);
    // R3: strobe held low for several cycles writes once
    step("R3", 0, 1, 1, 1, 0, 0, 7, 8'h0F);
    for (int k = 0; k < 3; k++) step("R3", 0, 1, 0, 1, 0, 0, 7, 8'h0F);
    step("R3", 0, 1, 1, 1, 0, 0, 7, 8'h0F); rd("R3", 7);
    // R6: no supply qualifier / output enable low
    step("R6", 0, 1, 1, 0, 0, 0, 9, 8'h00);
    step("R6", 0, 1, 0, 0, 0, 0, 9, 8'h00);
    step("R6", 0, 1, 1, 0, 0, 0, 9, 8'h00); rd("R6", 9);
    step("R5", 0, 0, 1, 1, 0, 0, 9, 8'h00);
    step("R5", 0, 0, 0, 1, 0, 0, 9, 8'h00);
    step("R5", 0, 0, 1, 1, 0, 0, 9, 8'h00); rd("R6", 9);
    // R7: chip enable high inhibits
    step("R7", 1, 1, 1, 1, 0, 0, 10, 8'h00);
    step("R7", 1, 1, 0, 1, 0, 0, 10, 8'h00);
    step("R7", 1, 1, 1, 1, 0, 0, 10, 8'h00); rd("R7", 10);
    // R5: output enable high with no supply gives no drive
    step("R5", 0, 1, 1, 0, 0, 0, 5, 8'h00);
    // R8: signature bytes, array untouched
    step("R8", 0, 0, 1, 0, 1, 0, 0, 8'h00);
    step("R8", 0, 0, 1, 0, 1, 0, 1, 8'h00);
    step("R8", 0, 0, 1, 0, 1, 0, 5, 8'h00);
    rd("R8", 5);
    // R1: walking pattern including the top address
    for (int i = 0; i < 16; i++) prog("R1", i * 61, ~(8'(1) << (i % 8)));
    prog("R1", (1 << AW) - 1, 8'h5A);
    for (int i = 0; i < 16; i++) rd("R1", i * 61);
    rd("R1", (1 << AW) - 1);
    // R2: erase restores ones; erase beats a strobe at the same edge
    step("R2", 1, 1, 1, 0, 0, 1, 0, 8'h00);
    rd("R2", 5); rd("R2", (1 << AW) - 1);
    step("R2", 0, 1, 1, 1, 0, 0, 5, 8'h00);
    step("R2", 0, 1, 0, 1, 0, 1, 5, 8'h00);
    step("R2", 0, 1, 1, 1, 0, 0, 5, 8'h00); rd("R2", 5);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule